// File: doc/BRIEF.md
# Parallel Bit Extract/Deposit Unit

This block is a 64-bit logical execution unit that performs two mask-driven bit permutations over one shared operand path. Extract walks the mask from its least significant bit upward and, for every set mask bit, copies the source bit at that position into the next free result position, packing the selected bits at the low end of the result. Deposit walks the mask the same way and, for every set mask bit, places the next unused source bit (taken from the least significant source bit upward) at that mask bit's position.

The operation is chosen by the 10-bit extended opcode of an X-form instruction under primary opcode 31. The source operand comes from the instruction's RS slot, the mask from its RB slot, and the result goes to the RA slot. Register-file access and pipeline control belong to the surrounding pipeline. The unit registers its result once, so a result appears one clock after its input strobe. No condition or status state is produced.

Top module: `bitperm_unit`

## Requirements
- R1: With extended opcode 10'b0010111100 (extract), result bit k equals the source bit at the position of the (k+1)-th set mask bit, counting set bits from mask bit 0 (least significant) upward.
- R2: With extended opcode 10'b0010011100 (deposit), at each set mask bit position p, result bit p equals source bit j, where j is the number of set mask bits below p.
- R3: Every result bit that no set mask bit selects is zero: in extract, all bits at and above the mask's popcount; in deposit, every position where the mask is zero.
- R4: Only the two extended opcode values in R1 and R2 are legal; each selects only its own operation.
- R5: Any other extended opcode, with in_valid high, gives out_valid high, out_illegal high and out_result zero one clock later.
- R6: out_valid is high exactly one clock after in_valid is high, and low one clock after in_valid is low; back-to-back inputs give back-to-back results.
- R7: While rst_n is low, out_valid, out_illegal and out_result are all zero.
- R8: A zero mask gives a zero result and an all-ones mask gives back the source unchanged, for both legal operations.
- R9: Whenever out_valid is low, out_result and out_illegal are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_xo | input | 10 | Extended opcode field of the instruction |
| in_src | input | 64 | Source operand (RS slot) |
| in_mask | input | 64 | Mask operand (RB slot) |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_illegal | output | 1 | Extended opcode was not extract or deposit |
| out_result | output | 64 | Permuted result (RA slot) |

## Verification
The bench aims at the mask shapes where a bit-ordering slip shows: a single set bit at the least significant end, which a reversed scan would send to bit 63; a single set bit at the most significant end, where an off-by-one rank would drop or misplace the bit; and alternating patterns, where swapped extract and deposit roles produce visibly different words. A zero mask catches a datapath that leaks source bits into unselected positions, and an all-ones mask catches a counter that skips or repeats a source bit. Opcodes one bit away from the legal ones check that the decoder does not accept near misses, and idle cycles between operations show whether a stale result or illegal flag lingers.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned XO_W   = 10;

    // Extended opcodes under primary opcode 31 (X-form)
    localparam logic [XO_W-1:0] XO_DEPOSIT = 10'b0010011100;
    localparam logic [XO_W-1:0] XO_EXTRACT = 10'b0010111100;

    typedef enum logic [1:0] {
        PERM_NONE    = 2'd0,
        PERM_EXTRACT = 2'd1,
        PERM_DEPOSIT = 2'd2
    } perm_op_e;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [DATA_W-1:0] result;
    } perm_stage_t;

endpackage

// File: rtl/bitperm_decode.sv
module bitperm_decode
    import bitperm_pkg::*;
#(
    parameter int unsigned XW = XO_W
) (
    input  logic [XW-1:0] xo,
    output perm_op_e      op
);

    always_comb begin
        if (xo == XW'(XO_EXTRACT)) begin
            op = PERM_EXTRACT;
        end else if (xo == XW'(XO_DEPOSIT)) begin
            op = PERM_DEPOSIT;
        end else begin
            op = PERM_NONE;
        end
    end

endmodule

// File: rtl/bitperm_gather.sv
module bitperm_gather #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res
);

    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

    logic [IDX_W-1:0] rank;

    // Scan from the least significant mask bit; each set bit claims the next packed slot
    always_comb begin
        res  = '0;
        rank = '0;
        for (int i = 0; i < W; i++) begin
            if (mask[i]) begin
                res[rank] = src[i];
                rank      = rank + 1'b1;
            end
        end
    end

    // R3: nothing above the popcount of the mask may be set
    always_comb begin
        a_r3_extract_high_zero: assert ((res >> $countones(mask)) == '0)
            else $error("extract result has bits above mask popcount");
    end

endmodule

// File: rtl/bitperm_scatter.sv
module bitperm_scatter #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res
);

    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

    logic [IDX_W-1:0] used;

    // Each set mask bit consumes the next unused low-order source bit
    always_comb begin
        res  = '0;
        used = '0;
        for (int i = 0; i < W; i++) begin
            if (mask[i]) begin
                res[i] = src[used];
                used   = used + 1'b1;
            end
        end
    end

    // R3: deposit never writes a position the mask leaves clear
    always_comb begin
        a_r3_deposit_unmasked_zero: assert ((res & ~mask) == '0)
            else $error("deposit wrote an unmasked position");
    end

endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
    import bitperm_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned XW = XO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [XW-1:0] in_xo,
    input  logic [W-1:0]  in_src,
    input  logic [W-1:0]  in_mask,
    output logic          out_valid,
    output logic          out_illegal,
    output logic [W-1:0]  out_result
);

    typedef struct packed {
        logic         valid;
        logic         illegal;
        logic [W-1:0] result;
    } stage_t;

    perm_op_e     op_sel;
    logic [W-1:0] ext_res;
    logic [W-1:0] dep_res;
    stage_t       stage_d;
    stage_t       stage_q;

    bitperm_decode #(.XW(XW)) u_decode (
        .xo (in_xo),
        .op (op_sel)
    );

    bitperm_gather #(.W(W)) u_gather (
        .src  (in_src),
        .mask (in_mask),
        .res  (ext_res)
    );

    bitperm_scatter #(.W(W)) u_scatter (
        .src  (in_src),
        .mask (in_mask),
        .res  (dep_res)
    );

    always_comb begin
        stage_d         = '0;
        stage_d.valid   = in_valid;
        if (in_valid) begin
            unique case (op_sel)
                PERM_EXTRACT: stage_d.result = ext_res;
                PERM_DEPOSIT: stage_d.result = dep_res;
                default:      stage_d.illegal = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid   = stage_q.valid;
    assign out_illegal = stage_q.illegal;
    assign out_result  = stage_q.result;

    // R6: one-clock latency on the strobe
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: illegal flag only with a valid, zero result
    a_r5_illegal_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && out_result == '0));

    // R4/R5: a legal opcode never flags illegal
    a_r4_legal_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_xo == XW'(XO_EXTRACT) || in_xo == XW'(XO_DEPOSIT)))
        |=> !out_illegal);

    // R9: quiet outputs when nothing is valid
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_result == '0 && !out_illegal));

    // R8: a full mask is the identity for both legal operations
    a_r8_full_mask_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mask == '1 &&
         (in_xo == XW'(XO_EXTRACT) || in_xo == XW'(XO_DEPOSIT)))
        |=> (out_result == $past(in_src)));

    // R8: an empty mask yields zero
    a_r8_empty_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mask == '0) |=> (out_result == '0));

endmodule

// File: tb/bitperm_unit_bench.sv
module bitperm_unit_bench;

    localparam int          W        = 64;
    localparam logic [9:0]  XO_EXT   = 10'b0010111100;
    localparam logic [9:0]  XO_DEP   = 10'b0010011100;
    localparam int          WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [9:0]    in_xo = '0;
    logic [W-1:0]  in_src = '0;
    logic [W-1:0]  in_mask = '0;
    logic          out_valid;
    logic          out_illegal;
    logic [W-1:0]  out_result;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    bitperm_unit u_bitperm_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_xo       (in_xo),
        .in_src      (in_src),
        .in_mask     (in_mask),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_result  (out_result)
    );

    // Bit-serial reference models
    function automatic logic [W-1:0] ref_extract(logic [W-1:0] s, logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin
                r[k] = s[i];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [W-1:0] ref_deposit(logic [W-1:0] s, logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin
                r[i] = s[k];
                k++;
            end
        end
        return r;
    endfunction

    task automatic compare(string tag, logic ev, logic ei, logic [W-1:0] er);
        n_vec++;
        if (out_valid !== ev || out_illegal !== ei || out_result !== er) begin
            n_fail++;
            $display("FAIL %s: got v=%0b ill=%0b res=%h, expected v=%0b ill=%0b res=%h",
                     tag, out_valid, out_illegal, out_result, ev, ei, er);
        end
    endtask

    // Drive one cycle of stimulus after a falling edge, check at the next falling edge
    task automatic apply(string tag, logic v, logic [9:0] xo,
                         logic [W-1:0] s, logic [W-1:0] m);
        logic          ev;
        logic          ei;
        logic [W-1:0]  er;
        in_valid = v;
        in_xo    = xo;
        in_src   = s;
        in_mask  = m;
        ev = v;
        ei = 1'b0;
        er = '0;
        if (v) begin
            if (xo == XO_EXT)      er = ref_extract(s, m);
            else if (xo == XO_DEP) er = ref_deposit(s, m);
            else                   ei = 1'b1;
        end
        @(negedge clk);
        compare(tag, ev, ei, er);
    endtask

    function automatic logic [W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        logic [W-1:0] s;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        compare("R7 reset", 1'b0, 1'b0, '0);
        in_valid = 1'b1;
        in_xo    = XO_BAD_SAMPLE();
        in_src   = '1;
        in_mask  = '1;
        @(negedge clk);
        compare("R7 reset holds with active inputs", 1'b0, 1'b0, '0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        compare("R9 idle after reset", 1'b0, 1'b0, '0);

        s = 64'hDEAD_BEEF_0123_4567;
        // R8 corner masks
        apply("R8 extract zero mask",   1'b1, XO_EXT, s, '0);
        apply("R8 deposit zero mask",   1'b1, XO_DEP, s, '0);
        apply("R8 extract full mask",   1'b1, XO_EXT, s, '1);
        apply("R8 deposit full mask",   1'b1, XO_DEP, s, '1);
        // R1/R2 single-bit masks at each end
        apply("R1 extract lsb mask",    1'b1, XO_EXT, 64'h1, 64'h1);
        apply("R1 extract msb mask",    1'b1, XO_EXT, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        apply("R2 deposit lsb mask",    1'b1, XO_DEP, 64'h1, 64'h1);
        apply("R2 deposit msb mask",    1'b1, XO_DEP, 64'h1, 64'h8000_0000_0000_0000);
        apply("R2 deposit msb mask src0", 1'b1, XO_DEP, 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0000);
        // R1/R2/R3 alternating patterns
        apply("R1 extract alt A",       1'b1, XO_EXT, s, 64'hAAAA_AAAA_AAAA_AAAA);
        apply("R1 extract alt 5",       1'b1, XO_EXT, '1, 64'h5555_5555_5555_5555);
        apply("R2 deposit alt A",       1'b1, XO_DEP, s, 64'hAAAA_AAAA_AAAA_AAAA);
        apply("R3 deposit alt 5 ones",  1'b1, XO_DEP, '1, 64'h5555_5555_5555_5555);
        apply("R3 extract high zero",   1'b1, XO_EXT, '1, 64'h00FF_0000_0000_0F00);
        // R9 idle cycle between operations
        apply("R9 idle quiet",          1'b0, XO_EXT, '1, '1);
        // R4/R5 near-miss and other opcodes
        apply("R5 opcode zero",         1'b1, 10'h000, s, '1);
        apply("R5 opcode all ones",     1'b1, 10'h3FF, s, '1);
        apply("R4 near extract",        1'b1, XO_EXT ^ 10'h001, s, '1);
        apply("R4 near deposit",        1'b1, XO_DEP ^ 10'h200, s, '1);
        apply("R9 illegal clears",      1'b0, 10'h000, s, '1);
        // R6 back-to-back alternating operations
        for (int i = 0; i < 8; i++) begin
            apply("R6 back-to-back", 1'b1, (i % 2 == 0) ? XO_EXT : XO_DEP, rnd64(), rnd64());
        end
        // R1/R2 random sweeps
        for (int i = 0; i < 200; i++) begin
            apply("R1 extract random", 1'b1, XO_EXT, rnd64(), rnd64());
        end
        for (int i = 0; i < 200; i++) begin
            apply("R2 deposit random", 1'b1, XO_DEP, rnd64(), rnd64());
        end
        // R6 strobe gaps among random operations
        for (int i = 0; i < 20; i++) begin
            apply("R6 sparse strobe", (i % 3) != 0, (i % 2 == 0) ? XO_DEP : XO_EXT, rnd64(), rnd64());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    function automatic logic [9:0] XO_BAD_SAMPLE();
        return 10'h155;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog: got no completion, expected finish within %0d cycles", WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule